// File: doc/BRIEF.md
# Translation Buffer with Page Permission Checking

This block translates every virtual address the processor issues (load, store or instruction fetch) into a physical address. It does so with a small, fully associative set of mapping entries. Each entry maps one 4 KiB virtual page to one physical page and carries three permission bits: read, write and execute. A lookup presents a virtual address and an access type. The result comes back one clock later. When the page is found and the access type is allowed, the page number is swapped and the 12 offset bits pass through unchanged. The block never walks page tables on its own. When no entry matches, it raises a miss so that software can fill an entry. When an entry matches but the access is not allowed, it raises a separate permission fault. Both faults report the offending virtual address.

Software loads entries through a write port that works only while the privilege input is high. The slot to overwrite comes from a rotating pointer unless the writer names a slot explicitly. A flush input invalidates every entry in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset (at start-up or in mid-run) every entry is invalid: rsp_valid, rsp_miss and rsp_perm_fault are 0, and any lookup misses.
- R2: A lookup presented with lu_valid=1 is answered exactly one clock later with rsp_valid=1; on a permitted hit rsp_paddr holds the entry's physical page number in bits 31:12.
- R3: Bits 11:0 of rsp_paddr equal bits 11:0 of the looked-up virtual address on every permitted hit.
- R4: A lookup whose page number (bits 31:12) matches no valid entry gives rsp_miss=1, rsp_perm_fault=0 and rsp_fault_vaddr equal to the looked-up address.
- R5: lu_acc encodes 0 = read, 1 = write, 2 = execute. wr_perm bit 2 grants read, bit 1 grants write and bit 0 grants execute. A hit whose access type has no grant gives rsp_perm_fault=1, rsp_miss=0 and rsp_fault_vaddr equal to the looked-up address.
- R6: rsp_miss and rsp_perm_fault are never 1 together. On either fault rsp_paddr is 0; on a permitted hit rsp_fault_vaddr is 0.
- R7: A write with wr_priv=0 changes no entry and does not move the rotating pointer.
- R8: A privileged write with wr_sel_idx=1 loads slot wr_idx and leaves the rotating pointer where it was.
- R9: A privileged write with wr_sel_idx=0 loads the slot under the rotating pointer. The pointer starts at 0 after reset, moves up by one on each such write and wraps from ENTRIES-1 to 0.
- R10: flush=1 invalidates all entries at the next edge. A write in the same cycle is dropped, and a lookup in the cycle after a flush misses.
- R11: When several valid entries hold the same page number, the lowest-numbered slot supplies both the translation and the permissions.
- R12: In a cycle after one with lu_valid=0, rsp_valid, rsp_miss and rsp_perm_fault are 0.
- R13: Access code 3 is granted by no permission bit, so a hit with it always gives rsp_perm_fault=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| wr_en | input | 1 | Entry write request |
| wr_priv | input | 1 | Privilege level of the writer; 1 allows the write |
| wr_sel_idx | input | 1 | 1: use wr_idx, 0: use the rotating pointer |
| wr_idx | input | IDX_W | Explicit slot number |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_ppn | input | 20 | Physical page number to install |
| wr_perm | input | 3 | Grants {read, write, execute} |
| lu_valid | input | 1 | Lookup request |
| lu_vaddr | input | 32 | Virtual address to translate |
| lu_acc | input | 2 | Access type |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address on a permitted hit, else 0 |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_perm_fault | output | 1 | Matched, but the access is not allowed |
| rsp_fault_vaddr | output | 32 | Faulting virtual address, else 0 |

## Verification
The properties assume that lu_valid and flush stay low while reset is asserted. A response, or a flush-then-lookup pair, that straddles the end of reset would otherwise be judged against a request the reset has wiped. The stimulus holds every request input at 0 for the whole of each reset pulse, including the one applied in mid-run, and raises requests only on falling clock edges after reset has dropped. The checks on address pass-through and fault addresses also take the lookup address to be stable for the one cycle it is sampled, and the bench drives each request for exactly one cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W     = 32;
    localparam int PA_W     = 32;
    localparam int PG_OFF_W = 12;
    localparam int VPN_W    = VA_W - PG_OFF_W;
    localparam int PPN_W    = PA_W - PG_OFF_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        perm_t             perm;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        RES_HIT  = 2'd0,
        RES_MISS = 2'd1,
        RES_PERM = 2'd2
    } res_e;

    function automatic logic perm_grants(perm_t p, acc_e a);
        logic g;
        case (a)
            ACC_LOAD:  g = p.rd;
            ACC_STORE: g = p.wr;
            ACC_FETCH: g = p.ex;
            default:   g = 1'b0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    we,
    input  logic [IDX_W-1:0]        widx,
    input  logic [VPN_W-1:0]        wvpn,
    input  logic [PPN_W-1:0]        wppn,
    input  perm_t                   wperm,
    output tlb_ent_t [ENTRIES-1:0]  ents_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ents_o[i] <= '0;
            end
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ents_o[i].valid <= 1'b0;
            end
        end else if (we) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (widx == IDX_W'(i)) begin
                    ents_o[i].valid <= 1'b1;
                    ents_o[i].vpn   <= wvpn;
                    ents_o[i].ppn   <= wppn;
                    ents_o[i].perm  <= wperm;
                end
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o <= '0;
        end else if (adv) begin
            ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]       vpn,
    input  acc_e                   acc,
    output res_e                   res_o,
    output logic [PPN_W-1:0]       ppn_o
);

    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   sel;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = ents[i].valid && (ents[i].vpn == vpn);
    end

    // lowest matching slot wins: scan from the top so the last write is the lowest
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = IDX_W'(i);
        end
    end

    always_comb begin
        ppn_o = ents[sel].ppn;
        if (match == '0) begin
            res_o = RES_MISS;
        end else if (!perm_grants(ents[sel].perm, acc)) begin
            res_o = RES_PERM;
        end else begin
            res_o = RES_HIT;
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic             wr_sel_idx,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [19:0]      wr_vpn,
    input  logic [19:0]      wr_ppn,
    input  logic [2:0]       wr_perm,
    input  logic             lu_valid,
    input  logic [31:0]      lu_vaddr,
    input  logic [1:0]       lu_acc,
    output logic             rsp_valid,
    output logic [31:0]      rsp_paddr,
    output logic             rsp_miss,
    output logic             rsp_perm_fault,
    output logic [31:0]      rsp_fault_vaddr
);

    tlb_ent_t [ENTRIES-1:0] ents;
    logic [IDX_W-1:0]       rr_ptr;
    logic                   wr_ok;
    logic                   rr_adv;
    logic [IDX_W-1:0]       wr_slot;
    res_e                   res;
    logic [PPN_W-1:0]       hit_ppn;

    // flush drops a write issued in the same cycle
    assign wr_ok   = wr_en && wr_priv && !flush;
    assign rr_adv  = wr_ok && !wr_sel_idx;
    assign wr_slot = wr_sel_idx ? wr_idx : rr_ptr;

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .we     (wr_ok),
        .widx   (wr_slot),
        .wvpn   (wr_vpn),
        .wppn   (wr_ppn),
        .wperm  (perm_t'(wr_perm)),
        .ents_o (ents)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk   (clk),
        .rst   (rst),
        .adv   (rr_adv),
        .ptr_o (rr_ptr)
    );

    tlb_lookup #(.ENTRIES(ENTRIES)) u_lookup (
        .ents  (ents),
        .vpn   (lu_vaddr[VA_W-1:PG_OFF_W]),
        .acc   (acc_e'(lu_acc)),
        .res_o (res),
        .ppn_o (hit_ppn)
    );

    always_ff @(posedge clk) begin
        if (rst || !lu_valid) begin
            rsp_valid       <= 1'b0;
            rsp_paddr       <= '0;
            rsp_miss        <= 1'b0;
            rsp_perm_fault  <= 1'b0;
            rsp_fault_vaddr <= '0;
        end else begin
            rsp_valid <= 1'b1;
            case (res)
                RES_HIT: begin
                    rsp_paddr       <= {hit_ppn, lu_vaddr[PG_OFF_W-1:0]};
                    rsp_miss        <= 1'b0;
                    rsp_perm_fault  <= 1'b0;
                    rsp_fault_vaddr <= '0;
                end
                RES_PERM: begin
                    rsp_paddr       <= '0;
                    rsp_miss        <= 1'b0;
                    rsp_perm_fault  <= 1'b1;
                    rsp_fault_vaddr <= lu_vaddr;
                end
                default: begin
                    rsp_paddr       <= '0;
                    rsp_miss        <= 1'b1;
                    rsp_perm_fault  <= 1'b0;
                    rsp_fault_vaddr <= lu_vaddr;
                end
            endcase
        end
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        lu_valid,
    input logic [31:0] lu_vaddr,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic        rsp_miss,
    input logic        rsp_perm_fault,
    input logic [31:0] rsp_fault_vaddr
);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lu_valid |=> rsp_valid);  // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lu_valid |=> (!rsp_valid && !rsp_miss && !rsp_perm_fault));  // R12

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        lu_valid |=> (rsp_miss || rsp_perm_fault ||
                      rsp_paddr[11:0] == $past(lu_vaddr[11:0])));  // R3

    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (rst)
        lu_valid |=> (!(rsp_miss || rsp_perm_fault) ||
                      rsp_fault_vaddr == $past(lu_vaddr)));  // R4

    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_miss && rsp_perm_fault));  // R6

    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss || rsp_perm_fault) |-> rsp_paddr == 32'd0);  // R6

    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && lu_valid) |=> rsp_miss);  // R10

endmodule

bind tlb_xlate tlb_xlate_chk u_chk (.*);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;

    localparam int ENTRIES = 4;

    // op: 0 lookup, 1 write via pointer, 2 write to explicit slot, 3 flush
    // kind: 0 permitted hit, 1 miss, 2 permission fault
    typedef struct packed {
        logic [1:0]  op;
        logic        priv;
        logic [1:0]  idx;
        logic [19:0] vpn;
        logic [19:0] ppn;
        logic [2:0]  perm;
        logic [31:0] va;
        logic [1:0]  acc;
        logic [1:0]  kind;
        logic [31:0] pa;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h12345678,2'd0,2'd1,32'h0,8'd1},          // R1 empty
        '{2'd1,1'b1,2'd0,20'h00010,20'hABCDE,3'b100,32'h0,2'd0,2'd0,32'h0,8'd9},         // slot0
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00010123,2'd0,2'd0,32'hABCDE123,8'd2},   // R2
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00010FFF,2'd1,2'd2,32'h0,8'd5},          // R5 write denied
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00010000,2'd2,2'd2,32'h0,8'd5},          // R5 exec denied
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00011000,2'd0,2'd1,32'h0,8'd4},          // R4
        '{2'd1,1'b0,2'd0,20'h00020,20'h11111,3'b111,32'h0,2'd0,2'd0,32'h0,8'd7},         // unprivileged
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00020004,2'd0,2'd1,32'h0,8'd7},          // R7
        '{2'd1,1'b1,2'd0,20'h00020,20'h22222,3'b010,32'h0,2'd0,2'd0,32'h0,8'd9},         // slot1
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00020ABC,2'd1,2'd0,32'h22222ABC,8'd3},   // R3
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00020ABC,2'd0,2'd2,32'h0,8'd5},          // R5 read denied
        '{2'd1,1'b1,2'd0,20'h00030,20'h33333,3'b001,32'h0,2'd0,2'd0,32'h0,8'd9},         // slot2
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00030010,2'd2,2'd0,32'h33333010,8'd5},   // R5 exec ok
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00030010,2'd3,2'd2,32'h0,8'd13},         // R13
        '{2'd1,1'b1,2'd0,20'h00040,20'h44444,3'b111,32'h0,2'd0,2'd0,32'h0,8'd9},         // slot3
        '{2'd1,1'b1,2'd0,20'h00050,20'h55555,3'b111,32'h0,2'd0,2'd0,32'h0,8'd9},         // wraps to slot0
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00010123,2'd0,2'd1,32'h0,8'd9},          // R9 evicted
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00050FFF,2'd0,2'd0,32'h55555FFF,8'd9},   // R9
        '{2'd2,1'b1,2'd3,20'h00030,20'h99999,3'b111,32'h0,2'd0,2'd0,32'h0,8'd8},         // slot3 explicit
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00030020,2'd0,2'd2,32'h0,8'd11},         // R11 slot2 rules
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00030020,2'd2,2'd0,32'h33333020,8'd11},  // R11
        '{2'd1,1'b1,2'd0,20'h00060,20'h66666,3'b100,32'h0,2'd0,2'd0,32'h0,8'd8},         // pointer still 1
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00020ABC,2'd1,2'd1,32'h0,8'd8},          // R8 slot1 replaced
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00060000,2'd0,2'd0,32'h66666000,8'd8},   // R8
        '{2'd2,1'b1,2'd2,20'h00077,20'h77777,3'b111,32'h0,2'd0,2'd0,32'h0,8'd8},         // slot2 explicit
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00030020,2'd0,2'd0,32'h99999020,8'd11},  // now slot3
        '{2'd3,1'b1,2'd0,20'h0,20'h0,3'b000,32'h0,2'd0,2'd0,32'h0,8'd10},                // flush
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00050FFF,2'd0,2'd1,32'h0,8'd10},         // R10
        '{2'd0,1'b1,2'd0,20'h0,20'h0,3'b000,32'h00077000,2'd0,2'd1,32'h0,8'd10}          // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_priv = 1'b0;
    logic        wr_sel_idx = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_ppn = '0;
    logic [2:0]  wr_perm = '0;
    logic        lu_valid = 1'b0;
    logic [31:0] lu_vaddr = '0;
    logic [1:0]  lu_acc = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_miss;
    logic        rsp_perm_fault;
    logic [31:0] rsp_fault_vaddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tlb_xlate #(.ENTRIES(ENTRIES)) u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_sel_idx(wr_sel_idx), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_perm(wr_perm),
        .lu_valid(lu_valid), .lu_vaddr(lu_vaddr), .lu_acc(lu_acc),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_miss(rsp_miss),
        .rsp_perm_fault(rsp_perm_fault), .rsp_fault_vaddr(rsp_fault_vaddr)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush = 1'b0; wr_en = 1'b0; wr_priv = 1'b0; wr_sel_idx = 1'b0;
        lu_valid = 1'b0;
    endtask

    // one cycle: drive on a falling edge, sample on the next falling edge
    task automatic lookup_check(input logic [31:0] va, input logic [1:0] acc,
                                input logic [1:0] kind, input logic [31:0] pa, input int req);
        logic [1:0]  act_kind;
        logic [31:0] exp_fva;
        lu_valid = 1'b1; lu_vaddr = va; lu_acc = acc;
        @(negedge clk);
        lu_valid = 1'b0;
        act_kind = {rsp_perm_fault, rsp_miss};
        exp_fva  = (kind == 2'd0) ? 32'h0 : va;
        chk(rsp_valid === 1'b1, $sformatf("R2 valid (vector R%0d)", req), {31'h0, rsp_valid}, 32'h1);
        chk(act_kind === kind, $sformatf("R%0d kind", req), {30'h0, act_kind}, {30'h0, kind});
        chk(rsp_paddr === pa, $sformatf("R%0d paddr (R6 zero on fault)", req), rsp_paddr, pa);
        chk(rsp_fault_vaddr === exp_fva, $sformatf("R%0d fault vaddr", req), rsp_fault_vaddr, exp_fva);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs quiet after reset
        chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        chk(rsp_miss === 1'b0 && rsp_perm_fault === 1'b0, "R1 faults after reset",
            {30'h0, rsp_perm_fault, rsp_miss}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                2'd0: lookup_check(VECS[v].va, VECS[v].acc, VECS[v].kind, VECS[v].pa, int'(VECS[v].req));
                2'd3: begin
                    flush = 1'b1;
                    @(negedge clk);
                    idle_inputs();
                end
                default: begin
                    wr_en = 1'b1; wr_priv = VECS[v].priv;
                    wr_sel_idx = (VECS[v].op == 2'd2); wr_idx = VECS[v].idx;
                    wr_vpn = VECS[v].vpn; wr_ppn = VECS[v].ppn; wr_perm = VECS[v].perm;
                    @(negedge clk);
                    idle_inputs();
                end
            endcase
        end

        // R12: no request, nothing reported
        @(negedge clk);
        chk(rsp_valid === 1'b0 && rsp_miss === 1'b0 && rsp_perm_fault === 1'b0, "R12 idle response",
            {29'h0, rsp_valid, rsp_perm_fault, rsp_miss}, 32'h0);

        // R10: a write together with a flush is dropped
        flush = 1'b1; wr_en = 1'b1; wr_priv = 1'b1; wr_sel_idx = 1'b0;
        wr_vpn = 20'h00080; wr_ppn = 20'h88888; wr_perm = 3'b111;
        @(negedge clk);
        idle_inputs();
        lookup_check(32'h00080000, 2'd0, 2'd1, 32'h0, 10);

        // R1: mid-run reset wipes a freshly loaded entry
        wr_en = 1'b1; wr_priv = 1'b1; wr_sel_idx = 1'b1; wr_idx = 2'd0;
        wr_vpn = 20'h00090; wr_ppn = 20'h90909; wr_perm = 3'b111;
        @(negedge clk);
        idle_inputs();
        lookup_check(32'h00090044, 2'd0, 2'd0, 32'h90909044, 8);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        lookup_check(32'h00090044, 2'd0, 2'd1, 32'h0, 1);

        // R9: pointer back at slot 0 after reset, wraps after ENTRIES writes
        for (int k = 0; k < ENTRIES + 1; k++) begin
            wr_en = 1'b1; wr_priv = 1'b1; wr_sel_idx = 1'b0;
            wr_vpn = 20'h00100 + 20'(k); wr_ppn = 20'h00A00 + 20'(k); wr_perm = 3'b100;
            @(negedge clk);
            idle_inputs();
        end
        lookup_check(32'h00100000, 2'd0, 2'd1, 32'h0, 9);
        lookup_check(32'h00104008, 2'd0, 2'd0, 32'h00A04008, 9);
        lookup_check(32'h00101008, 2'd0, 2'd0, 32'h00A01008, 9);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule